// File: doc/BRIEF.md
# SPI Command Bridge to NAND Byte Port and GPIO Expander

This block is an SPI slave that connects a host SPI bus to a byte-wide NAND data port and a nine-pin GPIO output bank. Each chip-select period starts with a command byte. The command byte picks the sequence of phases that follows: pass write bytes to the NAND port, fetch read bytes from it and shift them back to the host, load the low eight GPIO outputs, or drive the ninth GPIO output.

The SPI pins are oversampled in the system clock domain. They pass through a synchronizer, and the block detects SCK edges there. The NAND write data phase uses a two-bit-per-clock mode, with a second data input carrying one bit of each pair. The host always ends a write with one trailing filler byte. The block holds each write byte back until the next byte arrives, so the filler byte never reaches the NAND port.

Top module: `spi_nand_gpio_bridge`

## Requirements
- R1: SPI mode 0 is used. Bits are sampled on SCK rising edges, most significant bit first. The command byte always takes 8 clocks, one bit per clock on `mosi`.
- R2: Command 0x09 loads the next single-bit byte into `gpio[7:0]`. Any further bytes in the same select period leave `gpio` unchanged.
- R3: Commands 0x0C and 0x0D are one byte long. They set `gpio[8]` to bit 0 of the command and leave `gpio[7:0]` unchanged.
- R4: After command 0x08, every byte arrives two bits per rising edge, so a byte takes 4 clocks. `mosi_aux` carries the more significant bit of each pair and `mosi` carries the less significant bit.
- R5: During a write, every completed byte except the last one before CS rises gives exactly one `nand_wr` pulse with that byte on `nand_wdata`. The last byte is the trailing filler and is never written.
- R6: After command 0x0A, one byte is ignored before read data starts. After command 0x0B, four bytes are ignored.
- R7: `nand_rd` pulses at the end of the last ignored byte and at the end of each read byte. The value on `nand_rdata` during the pulse cycle is shifted out on `miso`, most significant bit first. Its first bit is valid after the falling edge that ends the preceding byte.
- R8: `miso` is low outside the read data phase, and always low while CS is high.
- R9: Raising `cs_n` at any point abandons the transaction and discards any partial byte. The next select period starts again with a command byte.
- R10: An unrecognised command makes the block ignore all further bytes until `cs_n` rises.
- R11: After reset, `gpio` is all zero, and `miso`, `nand_wr` and `nand_rd` are low.
- R12: `nand_wr` and `nand_rd` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI clock from the host, idles low |
| cs_n | input | 1 | Active-low select from the host |
| mosi | input | 1 | Host data in; lower bit of a pair in two-bit mode |
| mosi_aux | input | 1 | Second host data line; upper bit of a pair in two-bit mode |
| miso | output | 1 | Data to the host |
| nand_wdata | output | 8 | Write byte, valid while `nand_wr` is high |
| nand_wr | output | 1 | One-cycle write strobe |
| nand_rd | output | 1 | One-cycle read request; `nand_rdata` is taken in this cycle |
| nand_rdata | input | 8 | Read byte from the NAND port |
| gpio | output | 9 | GPIO outputs; bit 8 is the single-command pin |

## Verification
The in-RTL assertions check the following on every cycle:
- strobes are one cycle wide;
- writes only come out of the write phase, and read requests only come in the read phase;
- the GPIO bank changes only in the cycle after a completed byte;
- a high chip select returns the decoder to the command phase with `miso` quiet.

Some behaviour only the bench's scenarios can show: the exact byte values, the suppression of the trailing filler byte, and the per-opcode count of ignored bytes. The bench also shows the bit pairing in two-bit mode, the position of `miso` bits relative to SCK edges, and recovery after an abort in the middle of a byte.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OP_NAND_WR = 8'h08;
  localparam logic [7:0] OP_CFG_WR  = 8'h09;
  localparam logic [7:0] OP_NAND_RD = 8'h0A;
  localparam logic [7:0] OP_FAST_RD = 8'h0B;
  localparam logic [7:0] OP_PIN8_LO = 8'h0C;
  localparam logic [7:0] OP_PIN8_HI = 8'h0D;

  typedef enum logic [2:0] {
    PH_CMD, PH_CFG, PH_WDATA, PH_SKIP, PH_READ, PH_IGNORE
  } phase_e;

  // Shift one or two received bits into the byte, MSB first; in dual mode
  // the auxiliary line carries the upper bit of the pair.
  function automatic logic [BYTE_W-1:0] shift_in(input logic [BYTE_W-1:0] sr,
                                                 input logic dual,
                                                 input logic lo,
                                                 input logic hi);
    return dual ? {sr[BYTE_W-3:0], hi, lo} : {sr[BYTE_W-2:0], lo};
  endfunction

  function automatic int bit_step(input logic dual);
    return dual ? 2 : 1;
  endfunction

  function automatic phase_e decode_op(input logic [7:0] op);
    case (op)
      OP_NAND_WR:             return PH_WDATA;
      OP_CFG_WR:              return PH_CFG;
      OP_NAND_RD, OP_FAST_RD: return PH_SKIP;
      default:                return PH_IGNORE;
    endcase
  endfunction

  function automatic int skip_count(input logic [7:0] op, input int norm, input int fast);
    return (op == OP_FAST_RD) ? fast : norm;
  endfunction

  function automatic logic is_pin8_op(input logic [7:0] op);
    return (op == OP_PIN8_LO) || (op == OP_PIN8_HI);
  endfunction
endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int N = 4,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_async,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d_async[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/bridge_rx.sv
module bridge_rx
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              rise,
  input  logic              dual,
  input  logic              lo,
  input  logic              hi,
  output logic [BYTE_W-1:0] byte_q,
  output logic              done
);
  localparam int CW = $clog2(BYTE_W + 2);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  logic [CW-1:0]     cnt, cnt_nx;
  logic [BYTE_W-1:0] sr, sr_nx;

  always_comb begin
    sr_nx  = shift_in(sr, dual, lo, hi);
    cnt_nx = cnt + CW'(bit_step(dual));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; sr <= '0; byte_q <= '0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (clr) begin
        cnt <= '0; sr <= '0;
      end else if (rise) begin
        if (cnt_nx >= FULL) begin
          cnt <= '0; sr <= '0; byte_q <= sr_nx; done <= 1'b1;
        end else begin
          cnt <= cnt_nx; sr <= sr_nx;
        end
      end
    end
  end

  AST_RX_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt < FULL); // R1
  AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R12
endmodule

// File: rtl/bridge_tx.sv
module bridge_tx
  import bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fall,
  input  logic              load_req,
  input  logic [BYTE_W-1:0] din,
  input  logic              enable,
  output logic              miso
);
  logic [BYTE_W-1:0] sh, nxt;
  logic              armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0; nxt <= '0; armed <= 1'b0;
    end else if (clr) begin
      sh <= '0; nxt <= '0; armed <= 1'b0;
    end else begin
      if (load_req) begin
        nxt   <= din;
        armed <= 1'b1;
      end
      if (fall) begin
        if (armed) begin
          sh    <= nxt;
          armed <= load_req;
        end else begin
          sh <= {sh[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  assign miso = enable & sh[BYTE_W-1];

  AST_TX_FALL_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !miso); // R8
endmodule

// File: rtl/spi_nand_gpio_bridge.sv
module spi_nand_gpio_bridge
  import bridge_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NORM_SKIP   = 1,
  parameter int FAST_SKIP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic              mosi_aux,
  output logic              miso,
  output logic [BYTE_W-1:0] nand_wdata,
  output logic              nand_wr,
  output logic              nand_rd,
  input  logic [BYTE_W-1:0] nand_rdata,
  output logic [BYTE_W:0]   gpio
);
  localparam int MAXSKIP = (FAST_SKIP > NORM_SKIP) ? FAST_SKIP : NORM_SKIP;
  localparam int SKW     = $clog2(MAXSKIP + 1);

  // synchronised pins: {aux, mosi, cs_n, sck}; cs_n resets high
  logic [3:0] s_pins;
  bridge_sync #(.N(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({mosi_aux, mosi, cs_n, sck}), .q(s_pins));

  logic s_sck, cs_hi, s_mosi, s_aux, sck_d;
  assign s_sck  = s_pins[0];
  assign cs_hi  = s_pins[1];
  assign s_mosi = s_pins[2];
  assign s_aux  = s_pins[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= s_sck;
  end

  // named events used by the shifters and the assertions
  logic sck_rise, sck_fall;
  assign sck_rise = s_sck & ~sck_d & ~cs_hi;
  assign sck_fall = ~s_sck & sck_d & ~cs_hi;

  phase_e            phase;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done;
  logic              in_dual, in_read;
  assign in_dual = (phase == PH_WDATA);
  assign in_read = (phase == PH_READ);

  bridge_rx u_rx (
    .clk(clk), .rst_n(rst_n), .clr(cs_hi), .rise(sck_rise), .dual(in_dual),
    .lo(s_mosi), .hi(s_aux), .byte_q(rx_byte), .done(byte_done));

  logic [SKW-1:0]    skip_left;
  logic [BYTE_W-1:0] pend, wdata_q;
  logic              have_pend, wr_q, rd_q;
  logic [BYTE_W:0]   gpio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_CMD; skip_left <= '0; pend <= '0; have_pend <= 1'b0;
      wdata_q <= '0; wr_q <= 1'b0; rd_q <= 1'b0; gpio_q <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (cs_hi) begin
        phase     <= PH_CMD;
        have_pend <= 1'b0;
        skip_left <= '0;
      end else if (byte_done) begin
        case (phase)
          PH_CMD: begin
            phase     <= decode_op(rx_byte);
            skip_left <= SKW'(skip_count(rx_byte, NORM_SKIP, FAST_SKIP));
            if (is_pin8_op(rx_byte)) gpio_q[BYTE_W] <= rx_byte[0];
          end
          PH_CFG: begin
            gpio_q[BYTE_W-1:0] <= rx_byte;
            phase <= PH_IGNORE;
          end
          PH_WDATA: begin
            // hold each byte until the next one proves it was not the filler
            if (have_pend) begin
              wr_q    <= 1'b1;
              wdata_q <= pend;
            end
            pend      <= rx_byte;
            have_pend <= 1'b1;
          end
          PH_SKIP: begin
            skip_left <= skip_left - 1'b1;
            if (skip_left == SKW'(1)) begin
              phase <= PH_READ;
              rd_q  <= 1'b1;
            end
          end
          PH_READ: rd_q <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  bridge_tx u_tx (
    .clk(clk), .rst_n(rst_n), .clr(cs_hi), .fall(sck_fall), .load_req(rd_q),
    .din(nand_rdata), .enable(in_read), .miso(miso));

  assign nand_wr    = wr_q;
  assign nand_wdata = wdata_q;
  assign nand_rd    = rd_q;
  assign gpio       = gpio_q;

  AST_ABORT_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> (phase == PH_CMD)); // R9
  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_hi |=> !miso); // R8
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nand_wr |=> !nand_wr); // R12
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    nand_rd |=> !nand_rd); // R12
  AST_WR_FROM_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
    nand_wr |-> ($past(phase) == PH_WDATA)); // R5
  AST_RD_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    nand_rd |-> in_read); // R7
  AST_GPIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(gpio)); // R2
endmodule

// File: tb/sim_spi_nand_gpio_bridge.sv
`timescale 1ns/1ps
module sim_spi_nand_gpio_bridge;
  localparam int HALF = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, mosi_aux = 1'b0;
  logic miso, nand_wr, nand_rd;
  logic [7:0] nand_wdata, nand_rdata;
  logic [8:0] gpio;

  always #2.5 clk = ~clk;

  spi_nand_gpio_bridge u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .mosi_aux(mosi_aux), .miso(miso), .nand_wdata(nand_wdata),
    .nand_wr(nand_wr), .nand_rd(nand_rd), .nand_rdata(nand_rdata), .gpio(gpio));

  int checks = 0, fails = 0, quiet_bad = 0, wide_cnt = 0;
  int wr_cnt = 0, rd_seen = 0;
  logic [7:0] wr_log [64];
  logic wr_prev = 1'b0, rd_prev = 1'b0;
  bit done = 1'b0;

  function automatic logic [7:0] rpat(input int k);
    return 8'((k * 53 + 29) & 255);
  endfunction
  function automatic logic [7:0] wpat(input int k);
    return 8'((k * 91 + 75) & 255);
  endfunction

  // read-side model: the byte presented during pulse k is rpat(k)
  assign nand_rdata = rpat(rd_seen - 1);

  always @(negedge clk) begin
    if (nand_wr) begin
      if (wr_cnt < 64) wr_log[wr_cnt] = nand_wdata;
      wr_cnt++;
    end
    if (nand_rd) rd_seen++;
    if ((nand_wr && wr_prev) || (nand_rd && rd_prev)) wide_cnt++;
    wr_prev = nand_wr;
    rd_prev = nand_rd;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cs_begin;
    cs_n = 1'b0;
    clks(4);
  endtask

  task automatic cs_end;
    clks(HALF);
    cs_n = 1'b1;
    mosi = 1'b0; mosi_aux = 1'b0;
    clks(8);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = b[i];
      clks(HALF);
      if (miso) quiet_bad++;
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic send_dual(input logic [7:0] b, input int npairs);
    for (int p = 3; p > 3 - npairs; p--) begin
      mosi_aux = b[2*p+1];
      mosi     = b[2*p];
      clks(HALF);
      if (miso) quiet_bad++;
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic read_byte(output logic [7:0] b);
    b = '0;
    for (int i = 7; i >= 0; i--) begin
      mosi = 1'b0;
      clks(HALF);
      b[i] = miso;
      sck = 1'b1;
      clks(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cfg_write(input logic [7:0] v);
    cs_begin;
    send_bits(8'h09, 8);
    send_bits(v, 8);
    cs_end;
  endtask

  task automatic nand_write(input int n);
    int base;
    base = wr_cnt;
    cs_begin;
    send_bits(8'h08, 8);
    for (int j = 0; j < n; j++) send_dual(wpat(j), 4);
    send_dual(8'hFF, 4); // trailing filler byte
    cs_end;
    chk(wr_cnt - base == n, "R5 write count", wr_cnt - base, n);
    for (int j = 0; j < n; j++)
      chk(wr_log[base + j] == wpat(j), "R4 dual byte value", wr_log[base + j], wpat(j));
  endtask

  task automatic nand_read(input bit fast, input int n);
    int base;
    logic [7:0] b;
    base = rd_seen;
    cs_begin;
    send_bits(fast ? 8'h0B : 8'h0A, 8);
    for (int j = 0; j < (fast ? 4 : 1); j++) send_bits(8'h00, 8);
    for (int j = 0; j < n; j++) begin
      read_byte(b);
      chk(b == rpat(base + j), fast ? "R6 fast read byte" : "R6 read byte", b, rpat(base + j));
    end
    cs_end;
    chk(rd_seen - base == n + 1, "R7 read request count", rd_seen - base, n + 1);
  endtask

  initial begin
    #(190000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo;
    clks(5);
    rst_n = 1'b1;
    clks(3);
    @(negedge clk);
    chk(gpio == 9'h000, "R11 gpio reset", gpio, 0);
    chk(!miso, "R11 miso reset", miso, 0);
    chk(!nand_wr, "R11 wr reset", nand_wr, 0);
    chk(!nand_rd, "R11 rd reset", nand_rd, 0);

    // R1/R2 sweep of config values
    for (int i = 0; i < 64; i++) begin
      lo = 8'((i * 37 + 11) & 255);
      cfg_write(lo);
      @(negedge clk);
      chk(gpio == {1'b0, lo}, "R1 R2 config load", gpio, {1'b0, lo});
    end

    // R2: bytes after the config byte are ignored
    cs_begin;
    send_bits(8'h09, 8); send_bits(8'h3C, 8); send_bits(8'hFF, 8); send_bits(8'h00, 8);
    cs_end;
    @(negedge clk);
    chk(gpio == 9'h03C, "R2 extra bytes ignored", gpio, 9'h03C);

    // R3: ninth pin
    cs_begin; send_bits(8'h0D, 8); cs_end;
    @(negedge clk);
    chk(gpio == 9'h13C, "R3 pin8 high", gpio, 9'h13C);
    cs_begin; send_bits(8'h0D, 8); send_bits(8'h55, 8); cs_end;
    @(negedge clk);
    chk(gpio == 9'h13C, "R3 pin8 trailing byte ignored", gpio, 9'h13C);
    cs_begin; send_bits(8'h0C, 8); cs_end;
    @(negedge clk);
    chk(gpio == 9'h03C, "R3 pin8 low", gpio, 9'h03C);

    // R4/R5: dual writes of several lengths
    nand_write(1);
    nand_write(2);
    nand_write(6);
    nand_write(0);

    // R6/R7: reads
    nand_read(1'b0, 3);
    nand_read(1'b1, 3);
    nand_read(1'b0, 1);

    // R9: abort mid config byte, then fresh command
    cs_begin; send_bits(8'h09, 8); send_bits(8'hFF, 4); cs_end;
    @(negedge clk);
    chk(gpio == 9'h03C, "R9 aborted config keeps gpio", gpio, 9'h03C);
    cfg_write(8'h81);
    @(negedge clk);
    chk(gpio == 9'h081, "R9 decoder restarts", gpio, 9'h081);

    // R9: abort mid write byte
    begin
      int base;
      base = wr_cnt;
      cs_begin; send_bits(8'h08, 8); send_dual(8'h11, 4); send_dual(8'h22, 2); cs_end;
      chk(wr_cnt == base, "R9 aborted write emits nothing", wr_cnt - base, 0);
    end
    // R9: abort mid command byte
    cs_begin; send_bits(8'h0D, 5); cs_end;
    @(negedge clk);
    chk(gpio == 9'h081, "R9 partial command discarded", gpio, 9'h081);

    // R10: unknown opcode ignores the rest
    cs_begin; send_bits(8'h55, 8); send_bits(8'h09, 8); send_bits(8'hAA, 8); send_bits(8'h0D, 8); cs_end;
    @(negedge clk);
    chk(gpio == 9'h081, "R10 unknown opcode ignored", gpio, 9'h081);
    cs_begin; send_bits(8'h0E, 8); send_dual(8'h33, 4); send_dual(8'h44, 4); cs_end;
    chk(gpio == 9'h081, "R10 opcode 0x0E ignored", gpio, 9'h081);

    chk(quiet_bad == 0, "R8 miso low outside read data", quiet_bad, 0);
    chk(wide_cnt == 0, "R12 strobe width", wide_cnt, 0);
    @(negedge clk);
    chk(!miso, "R8 miso low while deselected", miso, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule